// File: doc/BRIEF.md
# Interrupt Record Queue with Pop-on-Read Registers

This block keeps interrupt records produced by a link receiver until software collects them. Each record pairs a 12-bit source identifier with a 32-bit data word. Records enter on a valid/ready push port and are stored in arrival order in a small queue of `DEPTH` entries (default 8). The pending flag stays high while at least one record waits.

Software reads the records through two registers on a simple access/write/address bus. The data register shows the data word of the oldest record and has no side effect. The source register shows the source of the oldest record, zero-extended to 32 bits, and removes that record in the same access. Software must therefore read the data register first and the source register second. Read data is registered and appears on the bus one cycle after the access.

The push side has no back-pressure to an upstream buffer. `push_ready` is low while the queue is full. A record offered while `push_ready` is low is discarded, and a sticky overflow flag is set that only reset clears.

Top module: `irq_record_fifo`

## Requirements
- R1: A record offered with `push_valid` high while `push_ready` is high is stored with its 12-bit source and 32-bit data intact. `push_ready` is high whenever fewer than `DEPTH` records are held.
- R2: The queue holds at most `DEPTH` records. While `DEPTH` are held, `push_ready` is low and an offered record is discarded, even if a pop happens in the same cycle.
- R3: `overflow` rises in the cycle after a record is offered while the queue is full, and stays high until reset.
- R4: A read access (`bus_acc`=1, `bus_wr`=0) at address 0x0F with a record pending returns the oldest source in `bus_rdata[11:0]`, with bits 31:12 zero. The same access removes that record.
- R5: A read access at address 0x10 with a record pending returns the oldest data word and leaves the queue unchanged.
- R6: `bus_rdata` is registered. It takes the value of an access on the clock edge that ends the access cycle, and it holds its value in cycles with `bus_acc` low.
- R7: A read at 0x0F or 0x10 while the queue is empty returns zero and removes nothing.
- R8: `irq_pending` is high exactly when at least one record is held.
- R9: Write accesses to any address, and read accesses to any address other than 0x0F and 0x10, return zero on `bus_rdata` and do not change the queue.
- R10: Records leave in arrival order. A push and a source-register pop in the same cycle both take effect.
- R11: During and right after reset the queue is empty, `push_ready` is 1, and `irq_pending`, `overflow` and `bus_rdata` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| push_valid | input | 1 | A record is offered |
| push_ready | output | 1 | Queue can accept a record (not full) |
| push_src | input | 12 | Source identifier of the offered record |
| push_data | input | 32 | Data word of the offered record |
| bus_acc | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write access (ignored), 0 = read |
| bus_addr | input | 5 | Register address |
| bus_rdata | output | 32 | Registered read data |
| irq_pending | output | 1 | At least one record is held |
| overflow | output | 1 | Sticky: a record was discarded while full |

## Verification
The embedded assertions check, on every cycle, that the occupancy never exceeds the depth, that the overflow flag never falls, that read data holds when there is no access, that an empty pop leaves the queue empty and returns zero, that a data-register read never lowers the pending flag, and that the pending flag only rises after a push. Only the bench's scenarios can show that records leave in arrival order with their fields intact. The scenarios also show that the data-then-source read sequence returns matching pairs, that simultaneous push and pop both take effect, and that writes and unmapped reads leave the contents untouched. For this, a behavioural queue model is compared against the ports on every clock.

// File: rtl/irqf_pkg.sv
package irqf_pkg;
  localparam int SRC_W  = 12;
  localparam int DATA_W = 32;
  localparam int BUS_W  = 32;
  localparam int ADDR_W = 5;
  localparam int SRC_REG_ADDR  = 15;
  localparam int DATA_REG_ADDR = 16;

  typedef struct packed {
    logic [SRC_W-1:0]  src;
    logic [DATA_W-1:0] data;
  } irq_rec_t;
endpackage

// File: rtl/irqf_store.sv
module irqf_store
  import irqf_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     push_en,
  input  irq_rec_t push_rec,
  input  logic     pop_en,
  output irq_rec_t head_rec,
  output logic     can_push,
  output logic     has_entry,
  output logic     ovf_flag
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  irq_rec_t         mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic             push_fire, pop_fire, is_full;

  assign is_full   = (count == FULL_CNT);
  assign push_fire = push_en && !is_full;
  assign pop_fire  = pop_en && (count != '0);
  assign can_push  = !is_full;
  assign has_entry = (count != '0);
  assign head_rec  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_fire) mem[wr_ptr] <= push_rec;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      count    <= '0;
      ovf_flag <= 1'b0;
    end else begin
      if (push_fire) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
      if (pop_fire)  rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
      case ({push_fire, pop_fire})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (push_en && is_full) ovf_flag <= 1'b1;
    end
  end

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (rst)
    count <= FULL_CNT);
  assert_full_drop_R2: assert property (@(posedge clk) disable iff (rst)
    (push_en && is_full && !pop_en) |=> (count == FULL_CNT));
  assert_overflow_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    ovf_flag |=> ovf_flag);
  assert_empty_pop_holds_R7: assert property (@(posedge clk) disable iff (rst)
    (pop_en && count == '0 && !push_en) |=> (count == '0));
endmodule

// File: rtl/irqf_regif.sv
module irqf_regif
  import irqf_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              acc,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  irq_rec_t          head_rec,
  input  logic              has_entry,
  output logic              pop_req,
  output logic [BUS_W-1:0]  rdata
);
  localparam logic [ADDR_W-1:0] SRC_A  = ADDR_W'(SRC_REG_ADDR);
  localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_REG_ADDR);

  logic             rd, sel_src, sel_data;
  logic [BUS_W-1:0] rd_mux;

  assign rd       = acc && !wr;
  assign sel_src  = rd && (addr == SRC_A);
  assign sel_data = rd && (addr == DATA_A);
  assign pop_req  = sel_src;

  always_comb begin
    rd_mux = '0;
    if (has_entry) begin
      if (sel_src)  rd_mux = {{(BUS_W-SRC_W){1'b0}}, head_rec.src};
      if (sel_data) rd_mux = BUS_W'(head_rec.data);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)      rdata <= '0;
    else if (acc) rdata <= rd_mux;
  end

  assert_rdata_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !acc |=> $stable(rdata));
  assert_empty_src_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (sel_src && !has_entry) |=> (rdata == '0));
endmodule

// File: rtl/irq_record_fifo.sv
module irq_record_fifo
  import irqf_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_valid,
  output logic              push_ready,
  input  logic [SRC_W-1:0]  push_src,
  input  logic [DATA_W-1:0] push_data,
  input  logic              bus_acc,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              irq_pending,
  output logic              overflow
);
  irq_rec_t in_rec, head_rec;
  logic     pop_req;

  assign in_rec.src  = push_src;
  assign in_rec.data = push_data;

  irqf_store #(.DEPTH(DEPTH)) store_i (
    .clk(clk), .rst(rst),
    .push_en(push_valid), .push_rec(in_rec),
    .pop_en(pop_req), .head_rec(head_rec),
    .can_push(push_ready), .has_entry(irq_pending), .ovf_flag(overflow)
  );

  irqf_regif regif_i (
    .clk(clk), .rst(rst),
    .acc(bus_acc), .wr(bus_wr), .addr(bus_addr),
    .head_rec(head_rec), .has_entry(irq_pending),
    .pop_req(pop_req), .rdata(bus_rdata)
  );

  assert_data_read_no_pop_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_acc && !bus_wr && bus_addr == ADDR_W'(DATA_REG_ADDR) && irq_pending)
      |=> irq_pending);
  assert_pending_rise_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_pending) |-> $past(push_valid));
endmodule

// File: tb/irq_record_fifo_tb_top.sv
`timescale 1ns/1ps
module irq_record_fifo_tb_top;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        push_valid = 1'b0;
  logic [11:0] push_src = '0;
  logic [31:0] push_data = '0;
  logic        bus_acc = 1'b0, bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        push_ready, irq_pending, overflow;
  logic [31:0] bus_rdata;

  always #10 clk = ~clk;

  irq_record_fifo #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .push_valid(push_valid), .push_ready(push_ready),
    .push_src(push_src), .push_data(push_data), .bus_acc(bus_acc),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
    .irq_pending(irq_pending), .overflow(overflow)
  );

  typedef struct { logic [11:0] src; logic [31:0] data; } rec_t;
  rec_t        q[$];
  logic [31:0] exp_rdata = '0;
  bit          exp_ovf = 0;
  bit          started = 0;
  bit          in_rst = 1;
  bit          done = 0;
  string       rd_tag = "R11";
  int          errors = 0, checks = 0;

  // Behavioural reference model, updated on every rising edge
  always @(posedge clk) begin
    bit was_full;
    started = 1;
    if (rst) begin
      q.delete(); exp_ovf = 0; exp_rdata = '0; in_rst = 1; rd_tag = "R11";
    end else begin
      in_rst = 0;
      was_full = (q.size() == DEPTH);
      if (bus_acc) begin
        if (!bus_wr && bus_addr == 5'h0F) begin
          if (q.size() > 0) begin
            exp_rdata = {20'd0, q[0].src};
            rd_tag = push_valid ? "R10" : "R4";
            void'(q.pop_front());
          end else begin
            exp_rdata = '0; rd_tag = "R7";
          end
        end else if (!bus_wr && bus_addr == 5'h10) begin
          exp_rdata = (q.size() > 0) ? q[0].data : 32'd0;
          rd_tag = (q.size() > 0) ? "R5" : "R7";
        end else begin
          exp_rdata = '0; rd_tag = "R9";
        end
      end else rd_tag = "R6";
      if (push_valid) begin
        if (was_full) exp_ovf = 1;
        else begin
          rec_t r; r.src = push_src; r.data = push_data; q.push_back(r);
        end
      end
    end
  end

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Compare against the model away from the active edge
  always @(negedge clk) begin
    if (started && !done) begin
      chk(in_rst ? "R11" : "R1/R2", "push_ready", {31'd0, push_ready}, {31'd0, q.size() < DEPTH});
      chk(in_rst ? "R11" : "R8", "irq_pending", {31'd0, irq_pending}, {31'd0, q.size() > 0});
      chk(in_rst ? "R11" : "R3", "overflow", {31'd0, overflow}, {31'd0, exp_ovf});
      chk(rd_tag, "bus_rdata", bus_rdata, exp_rdata);
    end
  end

  task automatic drive(bit pv, logic [11:0] s, logic [31:0] d, bit a, bit w, logic [4:0] ad);
    @(negedge clk);
    push_valid = pv; push_src = s; push_data = d;
    bus_acc = a; bus_wr = w; bus_addr = ad;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive(0, '0, '0, 0, 0, '0);
  endtask

  task automatic summary();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    idle(2);
    // R1 R2 R3: fill beyond depth, last offers dropped and flag overflow
    for (int i = 0; i < DEPTH + 2; i++)
      drive(1, 12'h100 + 12'(i), 32'hA5A5_0000 + 32'(i), 0, 0, '0);
    idle(2);
    // R9: writes and unmapped reads leave contents alone
    drive(0, '0, '0, 1, 1, 5'h0F);
    drive(0, '0, '0, 1, 1, 5'h10);
    drive(0, '0, '0, 1, 0, 5'h03);
    idle(2);
    // R5 R4 R6: data then source, one record per pair
    for (int i = 0; i < DEPTH; i++) begin
      drive(0, '0, '0, 1, 0, 5'h10);
      drive(0, '0, '0, 1, 0, 5'h10);
      drive(0, '0, '0, 0, 0, '0);
      drive(0, '0, '0, 1, 0, 5'h0F);
    end
    // R7: empty reads
    drive(0, '0, '0, 1, 0, 5'h0F);
    drive(0, '0, '0, 1, 0, 5'h10);
    idle(1);
    // R10: simultaneous push and pop
    drive(1, 12'hABC, 32'h1111_2222, 0, 0, '0);
    drive(1, 12'hDEF, 32'h3333_4444, 1, 0, 5'h0F);
    drive(1, 12'h123, 32'h5555_6666, 1, 0, 5'h0F);
    drive(0, '0, '0, 1, 0, 5'h10);
    drive(0, '0, '0, 1, 0, 5'h0F);
    idle(2);
    // Mixed traffic
    for (int i = 0; i < 3000; i++) begin
      logic [4:0] ad;
      int sel = int'($urandom % 4);
      ad = (sel == 0) ? 5'h0F : (sel == 1) ? 5'h10 : (sel == 2) ? 5'h0F : 5'($urandom);
      drive(($urandom % 2) == 0, 12'($urandom), $urandom,
            ($urandom % 3) != 0, ($urandom % 6) == 0, ad);
    end
    idle(3);
    // R11: reset clears everything
    @(negedge clk); rst = 1;
    idle(2);
    @(negedge clk); rst = 0;
    idle(2);
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R11 watchdog: actual=timeout expected=finish");
      summary();
    end
  end
endmodule